// File: doc/BRIEF.md
# Dual-Slot Instruction Issue Sequencer

This block sits between fetch and execute. It accepts one 32-bit fetched word at a time and issues its contents to the execute stage one slot per step. A word carries either a single long operation or two 15-bit short operations. A short pair is issued either in a fixed order or as a parallel pair. In a parallel pair, an operation that only tests a condition decides whether its partner runs.

The block shows the decode lookup indices of the held-in word on two outputs and takes back a one-bit "condition-test-only" attribute for each short operation in the same cycle. Each issue waits for the execute stage's ready. In the cycle after an issue, the execute stage returns three feedback bits: PC changed, exception, and condition result. A one-cycle done pulse marks the end of each word. Eight free-running event counters record what happened.

Top module: `slot_issue_seq`

## Requirements
- R1: Bits 31:30 of the word select the format: 2'b11 long, 2'b10 ordered pair right slot first, 2'b01 ordered pair left slot first, 2'b00 parallel pair. A long word issues exactly one slot, with slot_type 0, slot_right 0 and payload equal to word bits 29:0.
- R2: The left short operation is word bits 29:15 and the right one is bits 14:0. A short slot carries its operation zero-extended in the payload, and slot_right is 1 for the right operation.
- R3: An ordered pair issues its first operation with slot_type 1 and then the other operation with slot_type 2. The first operation is the right one for format 2'b10 and the left one for format 2'b01.
- R4: In an ordered pair, the second operation is not issued when the first returns PC-changed or exception. cnt_brskip increments only when PC-changed is set and exception is clear.
- R5: In a parallel pair, if the left operation is condition-test-only, it issues first with slot_type 5. Otherwise, if the right operation is condition-test-only, the right one issues first with slot_type 5. The partner then issues with slot_type 6 only when the condition result is 1. cnt_ctrue or cnt_cfalse records the outcome.
- R6: In a parallel pair with no condition-test operation, the left operation issues with slot_type 3 and then the right with slot_type 4. The right operation is not issued when the left returns exception.
- R7: idx_left equals word bits 29:24 and idx_right equals word bits 14:9, combinationally.
- R8: Each accepted word increments cnt_cycle and exactly one of cnt_long, cnt_par (both parallel kinds), cnt_lr or cnt_rl. cnt_cycle increments once more when the second operation of an ordered pair issues.
- R9: A slot is presented (slot_valid) only while ex_ready is 1. Otherwise the pending slot waits with its payload unchanged.
- R10: Feedback is sampled in the cycle right after each first issue. No slot and no done appear in that cycle.
- R11: done is high for exactly one cycle, in the cycle after the last issue or after a suppressing decision. word_ready is high only when the block is idle, which is the cycle after done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| word_valid | input | 1 | Fetched word offered |
| word | input | 32 | Fetched instruction word |
| word_ready | output | 1 | Idle, word accepted this cycle if valid |
| idx_left | output | 6 | Decode lookup index of left/long operation |
| idx_right | output | 6 | Decode lookup index of right operation |
| cond_left | input | 1 | Left operation is condition-test-only |
| cond_right | input | 1 | Right operation is condition-test-only |
| ex_ready | input | 1 | Execute stage can take a slot |
| fb_pc_chg | input | 1 | Issued operation changed the PC |
| fb_exc | input | 1 | Issued operation raised an exception |
| fb_cond | input | 1 | Condition result of a test operation |
| slot_valid | output | 1 | Slot issued this cycle |
| slot_right | output | 1 | Slot carries the right operation |
| slot_type | output | 3 | Slot type code (R1, R3, R5, R6) |
| slot_payload | output | 30 | Operation bits |
| done | output | 1 | Word fully handled |
| cnt_long | output | 16 | Long words |
| cnt_par | output | 16 | Parallel pairs |
| cnt_lr | output | 16 | Left-first ordered pairs |
| cnt_rl | output | 16 | Right-first ordered pairs |
| cnt_ctrue | output | 16 | Condition true outcomes |
| cnt_cfalse | output | 16 | Condition false outcomes |
| cnt_cycle | output | 16 | Issue cycles |
| cnt_brskip | output | 16 | Ordered seconds skipped by a branch |

## Verification
A wrong held mode or first-side bit shows up at the first issue of a word as a wrong slot_type or slot_right. A wrong suppression decision shows up two cycles after the first issue, either as an extra slot or as an early done. Counter faults remain visible: the counters are compared after every word, so an event that is missed or counted twice is caught at the next done pulse. Stalling ex_ready at random exposes payloads that change while waiting, or slots that issue without ready.

// File: rtl/sis_pkg.sv
package sis_pkg;
  typedef enum logic [1:0] {F_PAR = 2'b00, F_LR = 2'b01, F_RL = 2'b10, F_LONG = 2'b11} fmt_e;
  typedef enum logic [1:0] {M_LONG, M_ORD, M_CND, M_PAR} mode_e;
  typedef enum logic [2:0] {
    T_LONG = 3'd0, T_ORD1 = 3'd1, T_ORD2 = 3'd2, T_PARL = 3'd3,
    T_PARR = 3'd4, T_CTEST = 3'd5, T_CEXE = 3'd6
  } stype_e;
  localparam int EV_N    = 8;
  localparam int EV_LONG = 0;
  localparam int EV_PAR  = 1;
  localparam int EV_LR   = 2;
  localparam int EV_RL   = 3;
  localparam int EV_CT   = 4;
  localparam int EV_CF   = 5;
  localparam int EV_CYC  = 6;
  localparam int EV_BR   = 7;
endpackage

// File: rtl/sis_split.sv
module sis_split
  import sis_pkg::*;
#(
  parameter int OP_W  = 15,
  parameter int IDX_W = 6
) (
  input  logic [2*OP_W+1:0] word,
  input  logic              cond_l,
  input  logic              cond_r,
  output mode_e             mode,
  output logic              first_right,
  output logic [OP_W-1:0]   op_l,
  output logic [OP_W-1:0]   op_r,
  output logic [IDX_W-1:0]  idx_l,
  output logic [IDX_W-1:0]  idx_r
);
  localparam int WORD_W = 2*OP_W + 2;
  fmt_e fmt;

  assign fmt   = fmt_e'(word[WORD_W-1 -: 2]);
  assign op_l  = word[2*OP_W-1 -: OP_W];
  assign op_r  = word[OP_W-1:0];
  assign idx_l = word[2*OP_W-1 -: IDX_W];
  assign idx_r = word[OP_W-1 -: IDX_W];

  always_comb begin
    mode        = M_PAR;
    first_right = 1'b0;
    unique case (fmt)
      F_LONG: mode = M_LONG;
      F_RL: begin mode = M_ORD; first_right = 1'b1; end
      F_LR: mode = M_ORD;
      F_PAR: begin
        if (cond_l || cond_r) begin
          mode        = M_CND;
          first_right = !cond_l;
        end
      end
      default: mode = M_PAR;
    endcase
  end
endmodule

// File: rtl/sis_ctl.sv
module sis_ctl
  import sis_pkg::*;
#(
  parameter int OP_W = 15
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                word_valid,
  input  mode_e               mode_in,
  input  logic                first_right_in,
  input  logic [OP_W-1:0]     op_l_in,
  input  logic [OP_W-1:0]     op_r_in,
  input  logic                ex_ready,
  input  logic                fb_pc_chg,
  input  logic                fb_exc,
  input  logic                fb_cond,
  output logic                word_ready,
  output logic                slot_valid,
  output logic                slot_right,
  output logic [2:0]          slot_type,
  output logic [2*OP_W-1:0]   slot_payload,
  output logic                done,
  output logic [EV_N-1:0]     ev_inc
);
  localparam int LONG_W = 2*OP_W;
  typedef enum logic [2:0] {S_IDLE, S_ISS1, S_WAIT, S_ISS2, S_FIN} st_e;

  st_e             st_q, st_d;
  mode_e           mode_q;
  logic            first_r_q;
  logic [OP_W-1:0] opl_q, opr_q;
  logic            accept, cur_right;
  stype_e          typ;

  assign word_ready = (st_q == S_IDLE);
  assign accept     = word_valid && word_ready;
  assign slot_valid = ((st_q == S_ISS1) || (st_q == S_ISS2)) && ex_ready;
  assign done       = (st_q == S_FIN);

  // next state
  always_comb begin
    st_d = st_q;
    unique case (st_q)
      S_IDLE: if (accept) st_d = S_ISS1;
      S_ISS1: if (ex_ready) st_d = (mode_q == M_LONG) ? S_FIN : S_WAIT;
      S_WAIT: begin
        unique case (mode_q)
          M_ORD:   st_d = (fb_pc_chg || fb_exc) ? S_FIN : S_ISS2;
          M_CND:   st_d = fb_cond ? S_ISS2 : S_FIN;
          M_PAR:   st_d = fb_exc ? S_FIN : S_ISS2;
          default: st_d = S_FIN;
        endcase
      end
      S_ISS2: if (ex_ready) st_d = S_FIN;
      S_FIN:  st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= S_IDLE;
    else        st_q <= st_d;
  end

  // word hold registers, loaded on accept
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= M_LONG;
      first_r_q <= 1'b0;
      opl_q     <= '0;
      opr_q     <= '0;
    end else if (accept) begin
      mode_q    <= mode_in;
      first_r_q <= first_right_in;
      opl_q     <= op_l_in;
      opr_q     <= op_r_in;
    end
  end

  // slot content
  assign cur_right = (st_q == S_ISS2) ? !first_r_q : first_r_q;

  always_comb begin
    typ = T_LONG;
    if (st_q == S_ISS2) begin
      unique case (mode_q)
        M_ORD:   typ = T_ORD2;
        M_CND:   typ = T_CEXE;
        default: typ = T_PARR;
      endcase
    end else begin
      unique case (mode_q)
        M_LONG:  typ = T_LONG;
        M_ORD:   typ = T_ORD1;
        M_CND:   typ = T_CTEST;
        default: typ = T_PARL;
      endcase
    end
  end

  assign slot_type  = typ;
  assign slot_right = (mode_q != M_LONG) && cur_right;
  always_comb begin
    if (mode_q == M_LONG)  slot_payload = {opl_q, opr_q};
    else if (cur_right)    slot_payload = {{(LONG_W-OP_W){1'b0}}, opr_q};
    else                   slot_payload = {{(LONG_W-OP_W){1'b0}}, opl_q};
  end

  // event strobes
  always_comb begin
    ev_inc          = '0;
    ev_inc[EV_CYC]  = accept || ((st_q == S_ISS2) && ex_ready && (mode_q == M_ORD));
    ev_inc[EV_LONG] = accept && (mode_in == M_LONG);
    ev_inc[EV_PAR]  = accept && ((mode_in == M_PAR) || (mode_in == M_CND));
    ev_inc[EV_LR]   = accept && (mode_in == M_ORD) && !first_right_in;
    ev_inc[EV_RL]   = accept && (mode_in == M_ORD) && first_right_in;
    ev_inc[EV_CT]   = (st_q == S_WAIT) && (mode_q == M_CND) && fb_cond;
    ev_inc[EV_CF]   = (st_q == S_WAIT) && (mode_q == M_CND) && !fb_cond;
    ev_inc[EV_BR]   = (st_q == S_WAIT) && (mode_q == M_ORD) && fb_pc_chg && !fb_exc;
  end

  // checks
  a_r1_long_then_done: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_valid && slot_type == T_LONG) |=> done);
  a_r10_gap_after_first: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_valid && (slot_type == T_ORD1 || slot_type == T_CTEST || slot_type == T_PARL))
      |=> (!slot_valid && !done));
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && word_ready));
  a_r11_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
    word_ready |-> (!slot_valid && !done));
  a_r5_cond_false_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_valid && slot_type == T_CTEST) ##1 !fb_cond |=> done);
  a_r4_ord_suppress: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_valid && slot_type == T_ORD1) ##1 (fb_pc_chg || fb_exc) |=> done);
  a_r6_par_exc_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_valid && slot_type == T_PARL) ##1 fb_exc |=> done);
endmodule

// File: rtl/sis_evcnt.sv
module sis_evcnt
  import sis_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [EV_N-1:0]             inc,
  output logic [EV_N-1:0][CNT_W-1:0]  cnt
);
  for (genvar g = 0; g < EV_N; g++) begin : g_ctr
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt[g] <= '0;
      else if (inc[g]) cnt[g] <= cnt[g] + 1'b1;
    end
  end
endmodule

// File: rtl/slot_issue_seq.sv
module slot_issue_seq
  import sis_pkg::*;
#(
  parameter int OP_W  = 15,
  parameter int IDX_W = 6,
  parameter int CNT_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                word_valid,
  input  logic [2*OP_W+1:0]   word,
  output logic                word_ready,
  output logic [IDX_W-1:0]    idx_left,
  output logic [IDX_W-1:0]    idx_right,
  input  logic                cond_left,
  input  logic                cond_right,
  input  logic                ex_ready,
  input  logic                fb_pc_chg,
  input  logic                fb_exc,
  input  logic                fb_cond,
  output logic                slot_valid,
  output logic                slot_right,
  output logic [2:0]          slot_type,
  output logic [2*OP_W-1:0]   slot_payload,
  output logic                done,
  output logic [CNT_W-1:0]    cnt_long,
  output logic [CNT_W-1:0]    cnt_par,
  output logic [CNT_W-1:0]    cnt_lr,
  output logic [CNT_W-1:0]    cnt_rl,
  output logic [CNT_W-1:0]    cnt_ctrue,
  output logic [CNT_W-1:0]    cnt_cfalse,
  output logic [CNT_W-1:0]    cnt_cycle,
  output logic [CNT_W-1:0]    cnt_brskip
);
  logic [1:0]                  rst_sync;
  logic                        rst_ni;
  mode_e                       mode_w;
  logic                        first_r_w;
  logic [OP_W-1:0]             opl_w, opr_w;
  logic [EV_N-1:0]             ev;
  logic [EV_N-1:0][CNT_W-1:0]  cnt_all;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_ni = rst_sync[1];

  sis_split #(.OP_W(OP_W), .IDX_W(IDX_W)) u_split (
    .word(word), .cond_l(cond_left), .cond_r(cond_right),
    .mode(mode_w), .first_right(first_r_w), .op_l(opl_w), .op_r(opr_w),
    .idx_l(idx_left), .idx_r(idx_right)
  );

  sis_ctl #(.OP_W(OP_W)) u_ctl (
    .clk(clk), .rst_n(rst_ni), .word_valid(word_valid),
    .mode_in(mode_w), .first_right_in(first_r_w), .op_l_in(opl_w), .op_r_in(opr_w),
    .ex_ready(ex_ready), .fb_pc_chg(fb_pc_chg), .fb_exc(fb_exc), .fb_cond(fb_cond),
    .word_ready(word_ready), .slot_valid(slot_valid), .slot_right(slot_right),
    .slot_type(slot_type), .slot_payload(slot_payload), .done(done), .ev_inc(ev)
  );

  sis_evcnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_ni), .inc(ev), .cnt(cnt_all)
  );

  assign cnt_long   = cnt_all[EV_LONG];
  assign cnt_par    = cnt_all[EV_PAR];
  assign cnt_lr     = cnt_all[EV_LR];
  assign cnt_rl     = cnt_all[EV_RL];
  assign cnt_ctrue  = cnt_all[EV_CT];
  assign cnt_cfalse = cnt_all[EV_CF];
  assign cnt_cycle  = cnt_all[EV_CYC];
  assign cnt_brskip = cnt_all[EV_BR];
endmodule

// File: tb/tb_slot_issue_seq.sv
module tb_slot_issue_seq;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        word_valid;
  logic [31:0] word;
  logic        word_ready;
  logic [5:0]  idx_left, idx_right;
  logic        cond_left, cond_right, ex_ready, fb_pc_chg, fb_exc, fb_cond;
  logic        slot_valid, slot_right, done;
  logic [2:0]  slot_type;
  logic [29:0] slot_payload;
  logic [15:0] cnt_long, cnt_par, cnt_lr, cnt_rl, cnt_ctrue, cnt_cfalse, cnt_cycle, cnt_brskip;

  always #4 clk = ~clk;

  slot_issue_seq dut (
    .clk(clk), .rst_n(rst_n), .word_valid(word_valid), .word(word), .word_ready(word_ready),
    .idx_left(idx_left), .idx_right(idx_right), .cond_left(cond_left), .cond_right(cond_right),
    .ex_ready(ex_ready), .fb_pc_chg(fb_pc_chg), .fb_exc(fb_exc), .fb_cond(fb_cond),
    .slot_valid(slot_valid), .slot_right(slot_right), .slot_type(slot_type),
    .slot_payload(slot_payload), .done(done),
    .cnt_long(cnt_long), .cnt_par(cnt_par), .cnt_lr(cnt_lr), .cnt_rl(cnt_rl),
    .cnt_ctrue(cnt_ctrue), .cnt_cfalse(cnt_cfalse), .cnt_cycle(cnt_cycle), .cnt_brskip(cnt_brskip)
  );

  int n_chk = 0;
  int n_bad = 0;
  logic [33:0] exp_q[$];
  int e_long = 0, e_par = 0, e_lr = 0, e_rl = 0, e_ct = 0, e_cf = 0, e_cyc = 0, e_br = 0;
  logic stall_en = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(input logic ok, input string tag, input logic [33:0] act, input logic [33:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ready driver, changes away from the sampling edge
  initial begin
    ex_ready = 1'b1;
    forever begin
      @(posedge clk); #1;
      if (stall_en) begin
        lfsr     = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        ex_ready = lfsr[0] | lfsr[3];
      end else ex_ready = 1'b1;
    end
  end

  // monitor: pops expected slots (R9: payload only seen with slot_valid)
  logic [33:0] held;
  logic        held_v = 1'b0;
  initial begin
    forever begin
      @(negedge clk);
      if (slot_valid) begin
        held_v = 1'b0;
        if (exp_q.size() == 0) chk(1'b0, "R11 unexpected slot", {slot_type, slot_right, slot_payload}, '0);
        else begin
          logic [33:0] e;
          e = exp_q.pop_front();
          chk({slot_type, slot_right, slot_payload} == e, "R1/R2/R3/R5/R6 slot", {slot_type, slot_right, slot_payload}, e);
        end
      end else if (rst_n && !word_ready && !done && ex_ready === 1'b0) begin
        // R9: a stalled slot keeps its content
        if (held_v) chk({slot_type, slot_right, slot_payload} == held, "R9 stall hold", {slot_type, slot_right, slot_payload}, held);
        held   = {slot_type, slot_right, slot_payload};
        held_v = 1'b1;
      end else held_v = 1'b0;
    end
  end

  task automatic check_counts();
    chk(cnt_long == e_long[15:0],   "R8 cnt_long",   34'(cnt_long),   34'(e_long));
    chk(cnt_par == e_par[15:0],     "R8 cnt_par",    34'(cnt_par),    34'(e_par));
    chk(cnt_lr == e_lr[15:0],       "R8 cnt_lr",     34'(cnt_lr),     34'(e_lr));
    chk(cnt_rl == e_rl[15:0],       "R8 cnt_rl",     34'(cnt_rl),     34'(e_rl));
    chk(cnt_ctrue == e_ct[15:0],    "R5 cnt_ctrue",  34'(cnt_ctrue),  34'(e_ct));
    chk(cnt_cfalse == e_cf[15:0],   "R5 cnt_cfalse", 34'(cnt_cfalse), 34'(e_cf));
    chk(cnt_cycle == e_cyc[15:0],   "R8 cnt_cycle",  34'(cnt_cycle),  34'(e_cyc));
    chk(cnt_brskip == e_br[15:0],   "R4 cnt_brskip", 34'(cnt_brskip), 34'(e_br));
  endtask

  function automatic logic [33:0] item(input int t, input logic r, input logic [29:0] p);
    return {3'(t), r, p};
  endfunction

  // driver: model expected slots, offer word, wait for done
  task automatic send(input logic [31:0] w, input logic cl, input logic cr,
                      input logic pc, input logic ex, input logic cd);
    logic [14:0] lo, ro;
    int guard;
    lo = w[29:15]; ro = w[14:0];
    e_cyc++;
    case (w[31:30])
      2'b11: begin e_long++; exp_q.push_back(item(0, 1'b0, w[29:0])); end
      2'b10, 2'b01: begin
        logic rf;
        rf = (w[31:30] == 2'b10);
        if (rf) e_rl++; else e_lr++;
        exp_q.push_back(item(1, rf, rf ? 30'(ro) : 30'(lo)));
        if (!(pc || ex)) begin
          exp_q.push_back(item(2, !rf, rf ? 30'(lo) : 30'(ro)));
          e_cyc++;
        end else if (pc && !ex) e_br++;
      end
      default: begin
        e_par++;
        if (cl || cr) begin
          logic rf;
          rf = !cl;
          exp_q.push_back(item(5, rf, rf ? 30'(ro) : 30'(lo)));
          if (cd) begin e_ct++; exp_q.push_back(item(6, !rf, rf ? 30'(lo) : 30'(ro))); end
          else e_cf++;
        end else begin
          exp_q.push_back(item(3, 1'b0, 30'(lo)));
          if (!ex) exp_q.push_back(item(4, 1'b1, 30'(ro)));
        end
      end
    endcase
    @(negedge clk);
    guard = 0;
    while (!word_ready && guard < 100) begin @(negedge clk); guard++; end
    chk(word_ready, "R11 ready when idle", 34'(word_ready), 34'd1);
    word = w; cond_left = cl; cond_right = cr;
    fb_pc_chg = pc; fb_exc = ex; fb_cond = cd;
    word_valid = 1'b1;
    #1;
    chk({idx_left, idx_right} == {w[29:24], w[14:9]}, "R7 lookup index",
        34'({idx_left, idx_right}), 34'({w[29:24], w[14:9]}));
    @(negedge clk);
    word_valid = 1'b0;
    guard = 0;
    while (!done && guard < 200) begin @(negedge clk); guard++; end
    chk(done, "R11 done reached", 34'(done), 34'd1);
    chk(exp_q.size() == 0, "R4/R5/R6 all expected slots issued", 34'(exp_q.size()), 34'd0);
    exp_q.delete();
    check_counts();
    @(negedge clk);
    chk(!done && word_ready, "R11 done one cycle", 34'({done, word_ready}), 34'b01);
  endtask

  // R10: no slot in the cycle after a first issue (checked directly)
  task automatic gap_test();
    int t;
    e_cyc += 2; e_lr++;
    exp_q.push_back(item(1, 1'b0, 30'h0123));
    exp_q.push_back(item(2, 1'b1, 30'h0456));
    @(negedge clk);
    word = {2'b01, 15'h0123, 15'h0456}; cond_left = 0; cond_right = 0;
    fb_pc_chg = 0; fb_exc = 0; fb_cond = 0; word_valid = 1'b1;
    @(negedge clk); word_valid = 1'b0;
    chk(slot_valid, "R10 first issue cycle", 34'(slot_valid), 34'd1);
    @(negedge clk);
    chk(!slot_valid && !done, "R10 feedback cycle quiet", 34'({slot_valid, done}), 34'd0);
    @(negedge clk);
    chk(slot_valid, "R10 second issue follows", 34'(slot_valid), 34'd1);
    @(negedge clk);
    chk(done, "R11 done after last issue", 34'(done), 34'd1);
    t = exp_q.size();
    chk(t == 0, "R3 both issued", 34'(t), 34'd0);
    check_counts();
    @(negedge clk);
  endtask

  initial begin
    #(8*150000);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; word_valid = 1'b0; word = '0;
    cond_left = 0; cond_right = 0; fb_pc_chg = 0; fb_exc = 0; fb_cond = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(word_ready && !slot_valid && !done, "R11 reset state", 34'({word_ready, slot_valid, done}), 34'b100);
    check_counts();

    send(32'hC000_0000 | 32'h1234_5678 & 32'h3FFF_FFFF | 32'hC000_0000, 0, 0, 0, 0, 0); // R1 long
    send({2'b10, 15'h1ABC, 15'h0DEF}, 0, 0, 0, 0, 0); // R3 right first
    send({2'b01, 15'h7FFF, 15'h0001}, 0, 0, 0, 0, 0); // R3 left first, R2 fields
    send({2'b01, 15'h1111, 15'h2222}, 0, 0, 1, 0, 0); // R4 branch skip
    send({2'b10, 15'h3333, 15'h4444}, 0, 0, 0, 1, 0); // R4 exception, no brskip
    send({2'b10, 15'h5555, 15'h6666}, 0, 0, 1, 1, 0); // R4 both set, no brskip
    send({2'b00, 15'h0A0A, 15'h0B0B}, 1, 0, 0, 0, 1); // R5 left test true
    send({2'b00, 15'h0C0C, 15'h0D0D}, 1, 0, 0, 0, 0); // R5 left test false
    send({2'b00, 15'h0E0E, 15'h0F0F}, 0, 1, 0, 0, 1); // R5 right test true
    send({2'b00, 15'h1010, 15'h2020}, 0, 1, 0, 0, 0); // R5 right test false
    send({2'b00, 15'h3030, 15'h4040}, 1, 1, 0, 0, 1); // R5 left has priority
    send({2'b00, 15'h5050, 15'h6060}, 0, 0, 1, 0, 0); // R6 plain pair
    send({2'b00, 15'h7070, 15'h0808}, 0, 0, 0, 1, 1); // R6 exception suppresses right
    gap_test();                                        // R10

    stall_en = 1'b1;                                   // R9 stalls
    for (int i = 0; i < 40; i++) begin
      logic [31:0] w;
      w = {i[1:0] ^ 2'(i >> 2), 30'(32'h2545_F491 * (i + 7))};
      send(w, i[2], i[3], i[1], (i % 5) == 0, i[0]);
    end
    stall_en = 1'b0;
    repeat (3) @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule